// File: doc/BRIEF.md
# Accumulator Arithmetic Execution Unit

This block performs the arithmetic class of operations for an 8-bit accumulator machine. Each cycle in which `op_valid` is high, it takes an operation code together with the current accumulator, the B register, an operand byte, the three arithmetic flags and the 16-bit data pointer. One clock later it presents the new accumulator, B, incremented-byte, data-pointer and flag values, with `res_valid` high. Operand fetch, addressing and instruction sequencing belong to the surrounding core.

The operations are binary addition (with or without carry in), subtraction with borrow, a byte increment that returns its result on a separate output so any data byte can be bumped without passing through the accumulator, a whole 16-bit pointer increment, an unsigned 8x8 multiply and an unsigned 8/8 divide that both treat the accumulator and B as a register pair, and a decimal adjust. The decimal adjust is only meaningful straight after adding two packed BCD bytes: it reads the carry and auxiliary carry that the add left behind and corrects the accumulator to a two-digit BCD value.

Top module: `arith_exec_unit`

## Requirements
- R1: Code 0 (add) and code 1 (add with carry) give acc = acc_in + opnd_in (+ cy_in for code 1) mod 256; cy is the carry out of bit 7, ac the carry out of bit 3, ov the signed two's-complement overflow; b, byte and pointer outputs equal their inputs.
- R2: Code 2 (subtract with borrow) gives acc = acc_in - opnd_in - cy_in mod 256; cy is set when a borrow leaves bit 7, ac when a borrow leaves bit 3, ov on signed overflow.
- R3: Code 3 (byte increment) gives byte_out = opnd_in + 1 mod 256; acc, b, pointer and all three flags equal their inputs.
- R4: Code 4 (pointer increment) gives dptr_out = dptr_in + 1 mod 65536; acc, b, byte and all three flags equal their inputs.
- R5: Code 5 (multiply) puts the low byte of acc_in*b_in in acc and the high byte in b; cy is cleared, ov is set exactly when the product exceeds 255, ac is unchanged.
- R6: Code 6 (divide) with b_in nonzero puts the quotient of acc_in/b_in in acc and the remainder in b; cy and ov are cleared, ac is unchanged.
- R7: Code 6 with b_in equal to zero sets ov, clears cy and leaves acc and b at acc_in and b_in.
- R8: Code 7 (decimal adjust) adds 06h when the low nibble exceeds 9 or ac_in is set, then adds 60h when the high nibble exceeds 9 or carry is set; cy is set on either carry out of bit 7 and is never cleared; after adding two packed BCD bytes this yields their BCD sum mod 100 with cy set for sums of 100 or more.
- R9: Codes 8 to 15 change nothing: every result output equals the corresponding input.
- R10: Results appear exactly one clock after an accepted operation with res_valid high; in a cycle after op_valid is low, res_valid is low and all result outputs hold their last values.
- R11: While rst_n is low, res_valid and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see R1 to R9) |
| acc_in | input | 8 | Current accumulator |
| b_in | input | 8 | Current B register |
| opnd_in | input | 8 | Operand byte (also the byte to increment) |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| ov_in | input | 1 | Current overflow flag |
| dptr_in | input | 16 | Current data pointer |
| res_valid | output | 1 | Result outputs updated this cycle |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| byte_out | output | 8 | Incremented operand byte |
| dptr_out | output | 16 | New data pointer |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The hardest case is the decimal adjust acting on a genuine BCD addition whose auxiliary carry is set while the low nibble reads 9 or less, since that state only arises from a specific earlier add. The bench reaches it by issuing the add first, taking the accumulator, carry and auxiliary carry that its own model predicts, and feeding them straight into the decimal adjust that follows, then comparing the adjusted byte with the decimal sum of the two digit pairs. Divide by zero and the wrap of the byte and pointer increments at their all-ones values are driven directly as boundary vectors.

// File: rtl/aeu_pkg.sv
package aeu_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 16;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUBB  = 4'd2,
        OP_INCB  = 4'd3,
        OP_INCP  = 4'd4,
        OP_MUL   = 4'd5,
        OP_DIV   = 4'd6,
        OP_DADJ  = 4'd7
    } aeu_op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] byt;
        logic [PTR_W-1:0]  dptr;
        logic              cy;
        logic              ac;
        logic              ov;
    } aeu_state_t;

endpackage

// File: rtl/aeu_addsub.sv
module aeu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cy,
    output logic         ac,
    output logic         ov
);
    localparam int HW = W / 2;

    logic [W:0]  full_d;
    logic [HW:0] half_d;

    always_comb begin
        if (sub) begin
            full_d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
            half_d = {1'b0, a[HW-1:0]} - {1'b0, b[HW-1:0]} - {{HW{1'b0}}, cin};
        end else begin
            full_d = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
            half_d = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]} + {{HW{1'b0}}, cin};
        end
        res = full_d[W-1:0];
        cy  = full_d[W];
        ac  = half_d[HW];
        if (sub)
            ov = (a[W-1] != b[W-1]) && (full_d[W-1] != a[W-1]);
        else
            ov = (a[W-1] == b[W-1]) && (full_d[W-1] != a[W-1]);
    end
endmodule

// File: rtl/aeu_muldiv.sv
module aeu_muldiv #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod,
    output logic [W-1:0]   quo,
    output logic [W-1:0]   rem,
    output logic           dz
);
    logic [W:0] part_d [0:W];

    assign prod      = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    assign dz        = (b == '0);
    assign part_d[0] = '0;

    // restoring division, one quotient bit per stage, most significant first
    for (genvar s = 0; s < W; s++) begin : g_div
        logic [W:0] shifted_d;
        assign shifted_d = {part_d[s][W-1:0], a[W-1-s]};
        assign quo[W-1-s] = (shifted_d >= {1'b0, b});
        assign part_d[s+1] = quo[W-1-s] ? (shifted_d - {1'b0, b}) : shifted_d;
    end

    assign rem = part_d[W][W-1:0];
endmodule

// File: rtl/aeu_decadj.sv
module aeu_decadj #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic         acin,
    output logic [W-1:0] res,
    output logic         cy
);
    localparam int HW = W / 2;
    localparam logic [HW-1:0] MAXDIG = HW'(9);
    localparam logic [W:0] LO_FIX = (W+1)'(6);
    localparam logic [W:0] HI_FIX = (W+1)'(6) << HW;

    logic [W:0] step1_d;
    logic [W:0] step2_d;
    logic       c1_d;
    logic       lo_fix_d;
    logic       hi_fix_d;

    always_comb begin
        lo_fix_d = (a[HW-1:0] > MAXDIG) || acin;
        step1_d  = {1'b0, a} + (lo_fix_d ? LO_FIX : '0);
        c1_d     = cin || step1_d[W];
        hi_fix_d = (step1_d[W-1:HW] > MAXDIG) || c1_d;
        step2_d  = {1'b0, step1_d[W-1:0]} + (hi_fix_d ? HI_FIX : '0);
        res      = step2_d[W-1:0];
        cy       = c1_d || step2_d[W];
    end
endmodule

// File: rtl/aeu_incr.sv
module aeu_incr #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    assign y = x + W'(1);
endmodule

// File: rtl/arith_exec_unit.sv
module arith_exec_unit
    import aeu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              cy_in,
    input  logic              ac_in,
    input  logic              ov_in,
    input  logic [PTR_W-1:0]  dptr_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic [DATA_W-1:0] b_out,
    output logic [DATA_W-1:0] byte_out,
    output logic [PTR_W-1:0]  dptr_out,
    output logic              cy_out,
    output logic              ac_out,
    output logic              ov_out
);
    aeu_state_t st_d, st_q;

    logic [DATA_W-1:0]   as_res_d;
    logic                as_cy_d, as_ac_d, as_ov_d, as_sub_d, as_cin_d;
    logic [2*DATA_W-1:0] md_prod_d;
    logic [DATA_W-1:0]   md_quo_d, md_rem_d;
    logic                md_dz_d;
    logic [DATA_W-1:0]   da_res_d;
    logic                da_cy_d;
    logic [DATA_W-1:0]   inc_byte_d;
    logic [PTR_W-1:0]    inc_ptr_d;

    assign as_sub_d = (op_code == OP_SUBB);
    assign as_cin_d = (op_code == OP_ADD) ? 1'b0 : cy_in;

    aeu_addsub #(.W(DATA_W)) u_addsub (
        .a   (acc_in),
        .b   (opnd_in),
        .cin (as_cin_d),
        .sub (as_sub_d),
        .res (as_res_d),
        .cy  (as_cy_d),
        .ac  (as_ac_d),
        .ov  (as_ov_d)
    );

    aeu_muldiv #(.W(DATA_W)) u_muldiv (
        .a    (acc_in),
        .b    (b_in),
        .prod (md_prod_d),
        .quo  (md_quo_d),
        .rem  (md_rem_d),
        .dz   (md_dz_d)
    );

    aeu_decadj #(.W(DATA_W)) u_decadj (
        .a    (acc_in),
        .cin  (cy_in),
        .acin (ac_in),
        .res  (da_res_d),
        .cy   (da_cy_d)
    );

    aeu_incr #(.W(DATA_W)) u_inc_byte (
        .x (opnd_in),
        .y (inc_byte_d)
    );

    aeu_incr #(.W(PTR_W)) u_inc_ptr (
        .x (dptr_in),
        .y (inc_ptr_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (op_valid) begin
            st_d.valid = 1'b1;
            st_d.acc   = acc_in;
            st_d.b     = b_in;
            st_d.byt   = opnd_in;
            st_d.dptr  = dptr_in;
            st_d.cy    = cy_in;
            st_d.ac    = ac_in;
            st_d.ov    = ov_in;
            case (op_code)
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    st_d.acc = as_res_d;
                    st_d.cy  = as_cy_d;
                    st_d.ac  = as_ac_d;
                    st_d.ov  = as_ov_d;
                end
                OP_INCB: st_d.byt  = inc_byte_d;
                OP_INCP: st_d.dptr = inc_ptr_d;
                OP_MUL: begin
                    st_d.acc = md_prod_d[DATA_W-1:0];
                    st_d.b   = md_prod_d[2*DATA_W-1:DATA_W];
                    st_d.cy  = 1'b0;
                    st_d.ov  = (md_prod_d[2*DATA_W-1:DATA_W] != '0);
                end
                OP_DIV: begin
                    st_d.cy = 1'b0;
                    st_d.ov = md_dz_d;
                    if (!md_dz_d) begin
                        st_d.acc = md_quo_d;
                        st_d.b   = md_rem_d;
                    end
                end
                OP_DADJ: begin
                    st_d.acc = da_res_d;
                    st_d.cy  = da_cy_d;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign acc_out   = st_q.acc;
    assign b_out     = st_q.b;
    assign byte_out  = st_q.byt;
    assign dptr_out  = st_q.dptr;
    assign cy_out    = st_q.cy;
    assign ac_out    = st_q.ac;
    assign ov_out    = st_q.ov;
endmodule

// File: rtl/aeu_checker.sv
module aeu_checker
    import aeu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [CODE_W-1:0] op_code,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              cy_in,
    input logic              ac_in,
    input logic              ov_in,
    input logic [PTR_W-1:0]  dptr_in,
    input logic              res_valid,
    input logic [DATA_W-1:0] acc_out,
    input logic [DATA_W-1:0] b_out,
    input logic [DATA_W-1:0] byte_out,
    input logic [PTR_W-1:0]  dptr_out,
    input logic              cy_out,
    input logic              ac_out,
    input logic              ov_out
);
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) op_valid |=> res_valid); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !op_valid |=> (!res_valid && $stable(acc_out) && $stable(b_out) && $stable(dptr_out) && $stable(cy_out))); // R10
    AST_INCB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_INCB) |=> (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in) && acc_out == $past(acc_in))); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_INCP) |=> (dptr_out == $past(dptr_in) + 16'd1)); // R4
    AST_MUL_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_MUL) |=> ({b_out, acc_out} == {8'd0, $past(acc_in)} * {8'd0, $past(b_in)} && !cy_out && ov_out == (b_out != 8'd0))); // R5
    AST_DIV_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_DIV && b_in != 8'd0) |=> ({8'd0, acc_out} * {8'd0, $past(b_in)} + {8'd0, b_out} == {8'd0, $past(acc_in)} && b_out < $past(b_in) && !ov_out && !cy_out)); // R6
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_DIV && b_in == 8'd0) |=> (ov_out && !cy_out && acc_out == $past(acc_in) && b_out == $past(b_in))); // R7
    AST_DADJ_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_DADJ && cy_in) |=> cy_out); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (!res_valid && acc_out == 8'd0 && dptr_out == 16'd0)); // R11
endmodule

bind arith_exec_unit aeu_checker u_aeu_checker (.*);

// File: tb/arith_exec_unit_test.sv
module arith_exec_unit_test;

    typedef struct {
        int    code;
        int    acc;
        int    b;
        int    byt;
        int    dptr;
        int    cy;
        int    ac;
        int    ov;
        string req;
    } vec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [7:0]  acc_in = '0, b_in = '0, opnd_in = '0;
    logic        cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic [15:0] dptr_in = '0;
    logic        res_valid;
    logic [7:0]  acc_out, b_out, byte_out;
    logic [15:0] dptr_out;
    logic        cy_out, ac_out, ov_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    vec_t sb_q[$];

    always #4 clk = ~clk;

    arith_exec_unit uut (.*);

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic vec_t model(int code, int a, int b, int o, int c, int ac, int ov, int dp, string req);
        vec_t r;
        int s, ss, v, cc;
        r.code = code; r.acc = a; r.b = b; r.byt = o; r.dptr = dp;
        r.cy = c; r.ac = ac; r.ov = ov; r.req = req;
        case (code)
            0, 1: begin
                cc = (code == 1) ? c : 0;
                s = a + o + cc;
                r.acc = s % 256; r.cy = (s > 255);
                r.ac = ((a % 16) + (o % 16) + cc) > 15;
                ss = sgn(a) + sgn(o) + cc;
                r.ov = (ss > 127 || ss < -128);
            end
            2: begin
                s = a - o - c;
                r.acc = (s + 512) % 256; r.cy = (s < 0);
                r.ac = ((a % 16) - (o % 16) - c) < 0;
                ss = sgn(a) - sgn(o) - c;
                r.ov = (ss > 127 || ss < -128);
            end
            3: r.byt = (o + 1) % 256;
            4: r.dptr = (dp + 1) % 65536;
            5: begin
                s = a * b;
                r.acc = s % 256; r.b = s / 256; r.cy = 0; r.ov = (s > 255);
            end
            6: begin
                r.cy = 0;
                if (b == 0) r.ov = 1;
                else begin r.acc = a / b; r.b = a % b; r.ov = 0; end
            end
            7: begin
                v = a; cc = c;
                if ((v % 16) > 9 || ac != 0) v = v + 6;
                if (v > 255) cc = 1;
                v = v % 256;
                if ((v / 16) > 9 || cc != 0) v = v + 96;
                if (v > 255) cc = 1;
                r.acc = v % 256; r.cy = cc;
            end
            default: ;
        endcase
        return r;
    endfunction

    task automatic drive(int code, int a, int b, int o, int c, int ac, int ov, int dp, string req);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 4'(code);
        acc_in = 8'(a); b_in = 8'(b); opnd_in = 8'(o);
        cy_in = 1'(c); ac_in = 1'(ac); ov_in = 1'(ov);
        dptr_in = 16'(dp);
        sb_q.push_back(model(code, a, b, o, c, ac, ov, dp, req));
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 1'b0;
        acc_in = ~acc_in; b_in = ~b_in; opnd_in = ~opnd_in; dptr_in = ~dptr_in;
        cy_in = ~cy_in; op_code = 4'd5;
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: pop and compare each result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                vec_t e;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected result", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(int'(acc_out) == e.acc && int'(b_out) == e.b && int'(byte_out) == e.byt &&
                          int'(dptr_out) == e.dptr && int'(cy_out) == e.cy && int'(ac_out) == e.ac &&
                          int'(ov_out) == e.ov, e.req, $sformatf("code %0d {acc,b,byte,dptr,cy,ac,ov}", e.code),
                          {acc_out, b_out, byte_out, dptr_out[7:0], 5'd0, cy_out, ac_out, ov_out},
                          (e.acc << 32) | (e.b << 24) | (e.byt << 16) | ((e.dptr % 256) << 8) | (e.cy << 2) | (e.ac << 1) | e.ov);
                    if (int'(dptr_out) != e.dptr)
                        check(1'b0, e.req, "dptr", int'(dptr_out), e.dptr);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t r1;
        int xs[5] = '{8'h19, 8'h99, 8'h55, 8'h38, 8'h99};
        int ys[5] = '{8'h28, 8'h01, 8'h55, 8'h47, 8'h99};
        int dsum;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!res_valid && acc_out == 0 && b_out == 0 && byte_out == 0 && dptr_out == 0 &&
              !cy_out && !ac_out && !ov_out, "R11", "reset outputs", int'(acc_out), 0);
        rst_n = 1'b1;

        // R1 add / add with carry
        drive(0, 8'h7F, 0, 8'h01, 1, 0, 0, 16'h1234, "R1");
        drive(0, 8'hFF, 0, 8'h01, 0, 0, 1, 0, "R1");
        drive(1, 8'h80, 0, 8'h80, 1, 1, 0, 0, "R1");
        drive(1, 8'h0F, 0, 8'h00, 1, 0, 0, 0, "R1");
        for (int i = 0; i < 40; i++)
            drive(i % 2, (i * 37) % 256, 8'h3C, (i * 91 + 5) % 256, i % 3 == 0, 0, 0, 0, "R1");
        // R2 subtract with borrow
        drive(2, 8'h00, 0, 8'h01, 0, 0, 0, 0, "R2");
        drive(2, 8'h80, 0, 8'h01, 0, 0, 0, 0, "R2");
        drive(2, 8'h10, 0, 8'h0F, 1, 0, 1, 0, "R2");
        drive(2, 8'h05, 0, 8'h05, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 40; i++)
            drive(2, (i * 53 + 7) % 256, 0, (i * 29) % 256, i % 2, 1, 0, 0, "R2");
        // R3 byte increment, incl. wrap
        drive(3, 8'h12, 8'h34, 8'hFF, 1, 1, 1, 16'hABCD, "R3");
        drive(3, 8'h00, 8'h00, 8'h7F, 0, 0, 0, 0, "R3");
        // R4 pointer increment, incl. wrap
        drive(4, 8'h55, 8'h66, 8'h77, 1, 0, 1, 16'hFFFF, "R4");
        drive(4, 8'h00, 8'h00, 8'h00, 0, 1, 0, 16'h00FF, "R4");
        // R5 multiply
        drive(5, 8'hFF, 8'hFF, 0, 1, 1, 0, 0, "R5");
        drive(5, 8'h0F, 8'h11, 0, 1, 0, 1, 0, "R5");
        drive(5, 8'h10, 8'h10, 0, 0, 0, 0, 0, "R5");
        for (int i = 0; i < 20; i++)
            drive(5, (i * 41) % 256, (i * 13 + 1) % 256, 0, 1, i % 2, 0, 0, "R5");
        // R6 divide
        drive(6, 8'hFB, 8'h12, 0, 1, 1, 1, 0, "R6");
        drive(6, 8'h07, 8'h09, 0, 0, 0, 0, 0, "R6");
        drive(6, 8'hFF, 8'h01, 0, 1, 0, 0, 0, "R6");
        for (int i = 0; i < 20; i++)
            drive(6, (i * 67 + 3) % 256, (i * 7) % 255 + 1, 0, 1, 0, 1, 0, "R6");
        // R7 divide by zero
        drive(6, 8'hA5, 8'h00, 0, 1, 1, 0, 0, "R7");
        drive(6, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R7");
        // R8 decimal adjust on raw values
        drive(7, 8'h9A, 0, 0, 0, 0, 0, 0, "R8");
        drive(7, 8'h12, 0, 0, 1, 1, 0, 0, "R8");
        drive(7, 8'hFA, 0, 0, 0, 0, 1, 0, "R8");
        // R9 unused codes
        for (int c = 8; c < 16; c++)
            drive(c, c * 11, c * 5, c * 3, c % 2, 1, 0, 16'hBEEF, "R9");
        // R8 chained BCD additions: add, then adjust with the flags it produced
        for (int k = 0; k < 5; k++) begin
            r1 = model(0, xs[k], 0, ys[k], 0, 0, 0, 0, "R8");
            drive(0, xs[k], 0, ys[k], 0, 0, 0, 0, "R8");
            drive(7, r1.acc, 0, 0, r1.cy, r1.ac, r1.ov, 0, "R8");
            dsum = (xs[k] / 16) * 10 + xs[k] % 16 + (ys[k] / 16) * 10 + ys[k] % 16;
            @(negedge clk);
            op_valid = 1'b0;
            @(posedge clk);
            #1;
            check(int'(acc_out) == ((dsum % 100) / 10) * 16 + dsum % 10 && int'(cy_out) == (dsum >= 100),
                  "R8", "BCD sum", int'({cy_out, acc_out}), ((dsum >= 100) << 8) | (((dsum % 100) / 10) * 16 + dsum % 10));
        end
        // R10 hold while idle
        drive(0, 8'h21, 8'h43, 8'h11, 0, 0, 0, 16'h0101, "R10");
        idle();
        repeat (3) idle();
        #1;
        check(!res_valid && acc_out == 8'h32 && b_out == 8'h43 && dptr_out == 16'h0101,
              "R10", "idle hold", int'(acc_out), 8'h32);
        // R11 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!res_valid && acc_out == 0 && dptr_out == 0 && !cy_out, "R11", "async reset", int'(acc_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R10", "results outstanding", sb_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule